// File: doc/BRIEF.md
# Crossbar Pair Oscillator Comparator

This block produces a one-bit physical fingerprint by racing two oscillators. A challenge index is broken down into one column of a resistive cell grid and two different rows of that column. Outside this block, those addresses steer the two selected cells into a pair of current-starved ring oscillators, and the two oscillator outputs come back here. Only these two oscillators and two edge counters exist. They are reconfigured for every challenge, so there is no separate ring per cell.

After a start strobe the block checks the challenge and decodes it over several reference-clock cycles. It then clears both counters and counts the synchronized rising edges of each oscillator over a window of reference-clock cycles. When the window ends it compares the two counts, raises the response bit and pulses a completion flag for one cycle. For a grid of N columns and M rows there are N·M(M−1)/2 valid challenges. The default 40×40 grid has 31,200 of them, carried on a 15-bit index.

Top module: `pair_osc_puf`

## Requirements
- R1: A challenge index at or above N·M(M−1)/2 (31200 by default) is refused. err_o is high for one cycle after the edge that samples start_i, no measurement runs and done_o stays low.
- R2: Let P = M(M−1)/2. For a valid index i, col_o = i / P. The remainder r = i mod P selects the r-th pair (a,b) with a<b, where pairs are listed with a as the major key in ascending order: (0,1), (0,2) … (0,M−1), (1,2) and so on. At completion row_a_o = a and row_b_o = b.
- R3: done_o is high for exactly one cycle. It appears after clock edge c + a + W + 4, where the edge that samples start_i is edge 0, c is the column, a is the lower row and W is the effective window.
- R4: resp_o is 0 when the count from osc_a_i is lower than the count from osc_b_i, and 1 otherwise. resp_o holds its value until the next completion.
- R5: Equal counts give resp_o = 1.
- R6: A window value of 0 is treated as a window of 1 cycle.
- R7: From an accepted start until done_o, further start pulses are ignored. They produce no err_o, no extra done_o and no change to the result.
- R8: Each edge counter saturates at 2^CNT_W − 1 and never wraps.
- R9: After reset, done_o, err_o, resp_o, col_o, row_a_o and row_b_o are all 0.
- R10: Each oscillator passes through a two-flop synchronizer. Only rising edges inside the window are counted, and both counters are cleared before every measurement, so an earlier saturated run does not affect the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| challenge_i | input | CHAL_W | Challenge index |
| window_i | input | WIN_W | Measurement window in reference cycles, latched at start |
| osc_a_i | input | 1 | First oscillator, asynchronous |
| osc_b_i | input | 1 | Second oscillator, asynchronous |
| col_o | output | COL_W | Decoded column |
| row_a_o | output | ROW_W | Decoded lower row |
| row_b_o | output | ROW_W | Decoded higher row |
| resp_o | output | 1 | Response bit |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle invalid-challenge pulse |

## Verification
The refusal flag is due one edge after start is sampled. The completion pulse is due after edge c + a + W + 4, so its timing depends on the decoded column, the lower row and the window. The bench numbers clock edges and, when it issues each start, computes from its own enumeration of row pairs the exact edge at which each flag must rise. It samples on every falling edge, comparing both flags against that prediction and checking the addresses and response only in the predicted completion cycle. Oscillator periods are far enough apart that synchronizer phase cannot change the outcome of a comparison.

// File: rtl/pair_osc_puf_pkg.sv
package pair_osc_puf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECODE,
    ST_MEASURE,
    ST_COMPARE
  } ctl_state_e;

  typedef enum logic [1:0] {
    DP_IDLE,
    DP_COL,
    DP_ROW
  } dec_phase_e;

  function automatic int unsigned pair_count(int unsigned rows);
    return rows * (rows - 1) / 2;
  endfunction

endpackage

// File: rtl/pair_osc_puf_decode.sv
module pair_osc_puf_decode
  import pair_osc_puf_pkg::*;
#(
  parameter int unsigned NUM_COLS = 40,
  parameter int unsigned NUM_ROWS = 40,
  parameter int unsigned CHAL_W   = 15,
  localparam int unsigned COL_W   = $clog2(NUM_COLS),
  localparam int unsigned ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CHAL_W-1:0] index_i,
  output logic              fin_o,
  output logic [COL_W-1:0]  col_o,
  output logic [ROW_W-1:0]  row_a_o,
  output logic [ROW_W-1:0]  row_b_o
);

  localparam int unsigned PAIRS = pair_count(NUM_ROWS);
  localparam logic [CHAL_W-1:0] PAIRS_C = CHAL_W'(PAIRS);

  dec_phase_e        phase_q;
  logic [CHAL_W-1:0] rem_q;
  logic [COL_W-1:0]  col_q;
  logic [ROW_W-1:0]  ra_q, rb_q;
  logic              fin_q;
  logic [CHAL_W-1:0] row_span;

  // pairs left that start at the current lower row
  assign row_span = CHAL_W'(NUM_ROWS - 1) - CHAL_W'(ra_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= DP_IDLE;
      rem_q   <= '0;
      col_q   <= '0;
      ra_q    <= '0;
      rb_q    <= '0;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      unique case (phase_q)
        DP_IDLE: begin
          if (load_i) begin
            rem_q   <= index_i;
            col_q   <= '0;
            ra_q    <= '0;
            rb_q    <= '0;
            phase_q <= DP_COL;
          end
        end
        DP_COL: begin
          if (rem_q >= PAIRS_C) begin
            rem_q <= rem_q - PAIRS_C;
            col_q <= col_q + COL_W'(1);
          end else begin
            phase_q <= DP_ROW;
          end
        end
        DP_ROW: begin
          if (rem_q >= row_span) begin
            rem_q <= rem_q - row_span;
            ra_q  <= ra_q + ROW_W'(1);
          end else begin
            rb_q    <= ra_q + ROW_W'(1) + ROW_W'(rem_q);
            fin_q   <= 1'b1;
            phase_q <= DP_IDLE;
          end
        end
        default: phase_q <= DP_IDLE;
      endcase
    end
  end

  assign fin_o   = fin_q;
  assign col_o   = col_q;
  assign row_a_o = ra_q;
  assign row_b_o = rb_q;

endmodule

// File: rtl/pair_osc_puf_counter.sv
module pair_osc_puf_counter #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_i,
  input  logic             en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam int unsigned PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pipe_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[PIPE_W-2:0], osc_i};
  end

  assign rise = pipe_q[PIPE_W-2] & ~pipe_q[PIPE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (en_i && rise && (cnt_q != '1)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pair_osc_puf.sv
module pair_osc_puf
  import pair_osc_puf_pkg::*;
#(
  parameter int unsigned NUM_COLS = 40,
  parameter int unsigned NUM_ROWS = 40,
  parameter int unsigned CHAL_W   = 15,
  parameter int unsigned WIN_W    = 16,
  parameter int unsigned CNT_W    = 16,
  localparam int unsigned COL_W   = $clog2(NUM_COLS),
  localparam int unsigned ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CHAL_W-1:0] challenge_i,
  input  logic [WIN_W-1:0]  window_i,
  input  logic              osc_a_i,
  input  logic              osc_b_i,
  output logic [COL_W-1:0]  col_o,
  output logic [ROW_W-1:0]  row_a_o,
  output logic [ROW_W-1:0]  row_b_o,
  output logic              resp_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int unsigned TOTAL = NUM_COLS * pair_count(NUM_ROWS);
  localparam logic [CHAL_W:0] TOTAL_C = (CHAL_W + 1)'(TOTAL);

  ctl_state_e       state_q;
  logic [WIN_W-1:0] win_q, timer_q;
  logic             done_q, err_q, resp_q;
  logic             chal_ok, accept, dec_fin, cnt_clr, cnt_en, busy;
  logic [1:0]       osc_in;
  logic [CNT_W-1:0] cnt_q [2];

  assign chal_ok = {1'b0, challenge_i} < TOTAL_C;
  assign accept  = (state_q == ST_IDLE) && start_i && chal_ok;
  assign cnt_clr = (state_q == ST_DECODE) && dec_fin;
  assign cnt_en  = (state_q == ST_MEASURE);
  assign busy    = (state_q != ST_IDLE);
  assign osc_in  = {osc_b_i, osc_a_i};

  pair_osc_puf_decode #(
    .NUM_COLS (NUM_COLS),
    .NUM_ROWS (NUM_ROWS),
    .CHAL_W   (CHAL_W)
  ) u_decode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .index_i (challenge_i),
    .fin_o   (dec_fin),
    .col_o   (col_o),
    .row_a_o (row_a_o),
    .row_b_o (row_b_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    pair_osc_puf_counter #(
      .CNT_W       (CNT_W),
      .SYNC_STAGES (2)
    ) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .osc_i  (osc_in[g]),
      .en_i   (cnt_en),
      .clr_i  (cnt_clr),
      .cnt_o  (cnt_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      win_q   <= WIN_W'(1);
      timer_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      resp_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (chal_ok) begin
              state_q <= ST_DECODE;
              win_q   <= (window_i == '0) ? WIN_W'(1) : window_i;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_DECODE: begin
          if (dec_fin) begin
            state_q <= ST_MEASURE;
            timer_q <= '0;
          end
        end
        ST_MEASURE: begin
          if (timer_q == win_q - WIN_W'(1)) state_q <= ST_COMPARE;
          else                              timer_q <= timer_q + WIN_W'(1);
        end
        ST_COMPARE: begin
          resp_q  <= (cnt_q[0] >= cnt_q[1]);
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign resp_o = resp_q;
  assign done_o = done_q;
  assign err_o  = err_q;

endmodule

// File: rtl/pair_osc_puf_chk.sv
module pair_osc_puf_chk #(
  parameter int unsigned NUM_COLS = 40,
  parameter int unsigned NUM_ROWS = 40,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned COL_W    = 6,
  parameter int unsigned ROW_W    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_i,
  input logic             err_i,
  input logic             busy_i,
  input logic             clr_i,
  input logic [COL_W-1:0] col_i,
  input logic [ROW_W-1:0] row_a_i,
  input logic [ROW_W-1:0] row_b_i,
  input logic [CNT_W-1:0] cnt_a_i,
  input logic [CNT_W-1:0] cnt_b_i
);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R3

  AST_ROW_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (row_a_i < row_b_i)); // R2

  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (col_i <= COL_W'(NUM_COLS - 1) && row_b_i <= ROW_W'(NUM_ROWS - 1))); // R2

  AST_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !busy_i); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_a_i == '1) |=> (cnt_a_i == '1)); // R8

  AST_NO_OVERFLOW_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_b_i == '1) |=> (cnt_b_i == '1)); // R8

  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> ($stable(cnt_a_i) && $stable(cnt_b_i))); // R10

endmodule

bind pair_osc_puf pair_osc_puf_chk #(
  .NUM_COLS (NUM_COLS),
  .NUM_ROWS (NUM_ROWS),
  .CNT_W    (CNT_W),
  .COL_W    (COL_W),
  .ROW_W    (ROW_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .done_i  (done_o),
  .err_i   (err_o),
  .busy_i  (busy),
  .clr_i   (cnt_clr),
  .col_i   (col_o),
  .row_a_i (row_a_o),
  .row_b_i (row_b_o),
  .cnt_a_i (cnt_q[0]),
  .cnt_b_i (cnt_q[1])
);

// File: tb/sim_pair_osc_puf.sv
`timescale 1ns/1ps
module sim_pair_osc_puf;

  localparam int NC = 40;
  localparam int NR = 40;
  localparam int PAIRS = NR * (NR - 1) / 2;
  localparam int TOTAL = NC * PAIRS;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [14:0] challenge_i = '0;
  logic [15:0] window_i = '0;
  logic        osc_fast = 1'b0;
  logic        osc_slow = 1'b0;
  int          mode = 0;
  logic        osc_a_i, osc_b_i;
  logic [5:0]  col_o, row_a_o, row_b_o;
  logic        resp_o, done_o, err_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int exp_done_edge = -1;
  int exp_err_edge = -1;
  int exp_col, exp_ra, exp_rb, exp_resp;
  bit fin = 0;

  always #2 clk_i = ~clk_i;     // 250 MHz
  always #10 osc_fast = ~osc_fast;
  always #22 osc_slow = ~osc_slow;

  assign osc_a_i = (mode == 1) ? osc_slow : osc_fast;
  assign osc_b_i = (mode == 0) ? osc_slow : osc_fast;

  pair_osc_puf #(.CNT_W(4)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .challenge_i(challenge_i),
    .window_i(window_i), .osc_a_i(osc_a_i), .osc_b_i(osc_b_i), .col_o(col_o),
    .row_a_o(row_a_o), .row_b_o(row_b_o), .resp_o(resp_o), .done_o(done_o), .err_o(err_o)
  );

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, expv, cyc);
    end
  endtask

  // behavioural reference: column by division, pair by listing all pairs
  task automatic ref_decode(input int idx, output int c, output int a, output int b);
    int k, r;
    c = idx / PAIRS;
    r = idx % PAIRS;
    a = 0; b = 0; k = 0;
    for (int x = 0; x < NR; x++)
      for (int y = x + 1; y < NR; y++) begin
        if (k == r) begin a = x; b = y; end
        k++;
      end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !fin) begin
      check("R3 done timing", int'(done_o), int'(cyc == exp_done_edge));
      check("R1 err timing", int'(err_o), int'(cyc == exp_err_edge));
      if (cyc == exp_done_edge) begin
        check("R2 column", int'(col_o), exp_col);
        check("R2 lower row", int'(row_a_o), exp_ra);
        check("R2 upper row", int'(row_b_o), exp_rb);
        if (exp_resp >= 0) check("R4 response", int'(resp_o), exp_resp);
      end
    end
  end

  task automatic set_mode(input int m);
    @(negedge clk_i);
    mode = m;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic kick(input int chal, input int win, input int resp_exp);
    int c, a, b, weff;
    @(negedge clk_i);
    start_i = 1'b1;
    challenge_i = 15'(chal);
    window_i = 16'(win);
    if (chal >= TOTAL) begin
      exp_err_edge = cyc + 1;
    end else begin
      ref_decode(chal, c, a, b);
      weff = (win == 0) ? 1 : win;
      exp_done_edge = cyc + 1 + c + a + weff + 4;
      exp_col = c; exp_ra = a; exp_rb = b; exp_resp = resp_exp;
    end
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    int last;
    last = (exp_done_edge > exp_err_edge) ? exp_done_edge : exp_err_edge;
    while (cyc <= last + 2) @(negedge clk_i);
  endtask

  initial begin
    #100000;
    if (!fin) begin
      fails++; checks++;
      $display("FAIL R3 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 reset state
    check("R9 done", int'(done_o), 0);
    check("R9 err", int'(err_o), 0);
    check("R9 resp", int'(resp_o), 0);
    check("R9 col", int'(col_o), 0);
    check("R9 row_a", int'(row_a_o), 0);
    check("R9 row_b", int'(row_b_o), 0);

    set_mode(0);
    kick(0, 48, 1); wait_idle();              // R2 R4 fast on first input
    kick(PAIRS - 1, 8, -1); wait_idle();      // R2 last pair of column 0
    kick(PAIRS, 8, -1); wait_idle();          // R2 first pair of column 1
    set_mode(1);
    kick(TOTAL - 1, 48, 0); wait_idle();      // R2 R4 last valid, fast on second
    kick(TOTAL, 48, -1); wait_idle();         // R1 first invalid
    kick(32767, 48, -1); wait_idle();         // R1 max index
    set_mode(2);
    kick(1234, 48, 1); wait_idle();           // R5 equal counts
    kick(5, 0, -1); wait_idle();              // R6 zero window

    // R7 second start while busy, invalid index would otherwise raise err_o
    set_mode(0);
    kick(100, 48, 1);
    repeat (5) @(negedge clk_i);
    start_i = 1'b1; challenge_i = 15'(TOTAL);
    @(negedge clk_i);
    start_i = 1'b1; challenge_i = 15'(7);
    @(negedge clk_i);
    start_i = 1'b0;
    wait_idle();
    check("R7 no extra err", int'(err_o), 0);

    set_mode(1);
    kick(20000, 200, 1); wait_idle();         // R8 both saturate, equal
    kick(20000, 48, 0); wait_idle();          // R10 cleared after saturation

    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule